// File: doc/BRIEF.md
# Reservation Station Issue Selector with Oldest-Entry Bypass

This block is the issue stage of a small reservation station. It holds a fixed number of entries. Each entry has a micro-op, its operand data, a valid bit and a ready bit. On every cycle it offers one eligible entry on a valid/ready output stream. An eligible entry is one that is both valid and ready. New micro-ops arrive on a valid/ready input stream. Ready bits are set either when an entry is allocated or later by a plain per-entry wake vector.

Two pickers run in parallel on the same eligible set. The first is a fixed-priority picker that takes the lowest-index entry. The second is an age matrix that finds the entry allocated earliest. The micro-op array and the operand array each have two combinational read ports, one addressed by each picker. Both reads therefore happen in the same cycle as selection. A final multiplexer steers the oldest entry's contents to the output whenever the age logic is built in and any entry is eligible. The build parameter `AGE_EN` removes the age matrix. With it removed, only the lowest-index pick is used, as would be chosen for a station that feeds simple integer units.

Back-pressure rules are as follows. An issue happens only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, no entry leaves. The input is accepted only on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low exactly when every entry is occupied. It never depends on `in_valid` or on `out_ready`.

Top module: `rs_issue_sel`

## Requirements
- R1: After reset no entry is occupied, so `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 while at least one entry is free. An accepted input is written into the lowest-numbered free entry. An input offered while `in_ready` is 0 is dropped and changes no entry.
- R3: An entry is eligible when it is occupied and its ready bit is set. The ready bit takes the value of `in_rdy` at allocation. Bit i of `wake` sets it for entry i if that entry is occupied. Wake bits for free entries have no effect. `out_valid` is 1 exactly when some entry is eligible.
- R4: With `AGE_EN`=1, the output shows the eligible entry that was accepted earliest, and `out_oldest` is 1. An eligible entry is therefore never passed over while a younger one issues.
- R5: With `AGE_EN`=0, the output shows the eligible entry with the lowest index, and `out_oldest` is 0.
- R6: `out_uop` and `out_data` equal the micro-op and data stored in entry `out_idx`, in the same cycle, with no register in between.
- R7: While `out_valid` is 1 and `out_ready` is 0, no entry is removed, and `out_valid` stays 1 on the next cycle.
- R8: On a clock edge where `out_valid` and `out_ready` are both 1, entry `out_idx` is freed. From the next cycle it is neither shown nor eligible, and it may be allocated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | New micro-op offered |
| in_ready | output | 1 | A free entry exists |
| in_uop | input | UW | Micro-op of the offered entry |
| in_data | input | DW | Operand data of the offered entry |
| in_rdy | input | 1 | Offered entry is ready at allocation |
| wake | input | N | Per-entry ready set |
| out_valid | output | 1 | An eligible entry is shown |
| out_ready | input | 1 | Consumer takes the shown entry |
| out_uop | output | UW | Micro-op of the shown entry |
| out_data | output | DW | Operand data of the shown entry |
| out_idx | output | IW | Index of the shown entry |
| out_oldest | output | 1 | Shown entry came from the age path |

## Verification
The outputs `out_valid`, `out_idx`, `out_uop`, `out_data`, `out_oldest` and `in_ready` are combinational from the entry state. They therefore reflect a stimulus one clock edge after it is applied: allocation, wake and issue all take effect at that edge. The bench drives inputs just after a falling edge and advances its behavioural model by one step. It then compares every output against the model at the next falling edge. That falling edge lies after the rising edge that consumes the stimulus, so no comparison lands on an edge. Two instances, one with and one without the age logic, receive the same stimulus. Each is compared against its own model on every cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic {
    SRC_NORMAL = 1'b0,
    SRC_OLDEST = 1'b1
  } sel_src_e;
endpackage

// File: rtl/rs_prio_pick.sv
module rs_prio_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        idx    = IW'(i);
      end
      any = any | req[i];
    end
  end
endmodule

// File: rtl/rs_age_matrix.sv
module rs_age_matrix #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alloc_en,
  input  logic [N-1:0] alloc_oh,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  // older_q[i][j] set: entry i was accepted before entry j
  logic [N-1:0] older_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else if (alloc_en) begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (alloc_oh[i])      older_q[i][j] <= 1'b0;
          else if (alloc_oh[j]) older_q[i][j] <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_row
    localparam logic [N-1:0] SELF = N'(1) << g;
    // an entry wins when no other requester is older than it
    assign gnt[g] = req[g] & ~|(req & ~older_q[g] & ~SELF);
  end

  assign any = |req;
endmodule

// File: rtl/rs_payload_ram.sv
module rs_payload_ram #(
  parameter int N = 8,
  parameter int W = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ra_idx,
  output logic [W-1:0]  ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic [W-1:0]  rb_data
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
endmodule

// File: rtl/rs_issue_sel.sv
module rs_issue_sel
  import rs_pkg::*;
#(
  parameter int N      = 8,
  parameter int UW     = 16,
  parameter int DW     = 32,
  parameter bit AGE_EN = 1'b1,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [UW-1:0] in_uop,
  input  logic [DW-1:0] in_data,
  input  logic          in_rdy,
  input  logic [N-1:0]  wake,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [UW-1:0] out_uop,
  output logic [DW-1:0] out_data,
  output logic [IW-1:0] out_idx,
  output logic          out_oldest
);
  logic [N-1:0]  vld, rdy, elig;
  logic [N-1:0]  alloc_oh, gnt_norm, gnt_old, iss_oh;
  logic [IW-1:0] alloc_idx, idx_norm, idx_old;
  logic          any_norm, any_old, alloc_fire, issue_fire;
  sel_src_e      src;
  logic [UW-1:0] uop_norm, uop_old;
  logic [DW-1:0] dat_norm, dat_old;

  // free-slot finder doubles as the input-side ready
  rs_prio_pick #(.N(N)) u_alloc_pick (
    .req(~vld), .gnt(alloc_oh), .idx(alloc_idx), .any(in_ready)
  );

  assign elig       = vld & rdy;
  assign alloc_fire = in_valid & in_ready;

  rs_prio_pick #(.N(N)) u_norm_pick (
    .req(elig), .gnt(gnt_norm), .idx(idx_norm), .any(any_norm)
  );

  if (AGE_EN) begin : g_age
    rs_age_matrix #(.N(N)) u_age (
      .clk(clk), .rst_n(rst_n), .alloc_en(alloc_fire), .alloc_oh(alloc_oh),
      .req(elig), .gnt(gnt_old), .any(any_old)
    );
  end else begin : g_no_age
    assign gnt_old = '0;
    assign any_old = 1'b0;
  end

  always_comb begin
    idx_old = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt_old[i]) idx_old = idx_old | IW'(i);
    end
  end

  // both arrays read at both picks in parallel with the final choice
  rs_payload_ram #(.N(N), .W(UW)) u_uop_ram (
    .clk(clk), .we(alloc_fire), .waddr(alloc_idx), .wdata(in_uop),
    .ra_idx(idx_norm), .ra_data(uop_norm), .rb_idx(idx_old), .rb_data(uop_old)
  );

  rs_payload_ram #(.N(N), .W(DW)) u_data_ram (
    .clk(clk), .we(alloc_fire), .waddr(alloc_idx), .wdata(in_data),
    .ra_idx(idx_norm), .ra_data(dat_norm), .rb_idx(idx_old), .rb_data(dat_old)
  );

  assign src        = (AGE_EN && any_old) ? SRC_OLDEST : SRC_NORMAL;
  assign out_valid  = any_norm;
  assign out_oldest = (src == SRC_OLDEST);
  assign out_idx    = out_oldest ? idx_old : idx_norm;
  assign out_uop    = out_oldest ? uop_old : uop_norm;
  assign out_data   = out_oldest ? dat_old : dat_norm;

  assign issue_fire = out_valid & out_ready;
  assign iss_oh     = issue_fire ? (N'(1) << out_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      rdy <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (alloc_fire && alloc_oh[i]) begin
          vld[i] <= 1'b1;
          rdy[i] <= in_rdy;
        end else begin
          vld[i] <= vld[i] & ~iss_oh[i];
          rdy[i] <= (rdy[i] | (wake[i] & vld[i])) & ~iss_oh[i];
        end
      end
    end
  end
endmodule

// File: rtl/rs_issue_sel_chk.sv
module rs_issue_sel_chk #(
  parameter int N      = 8,
  parameter bit AGE_EN = 1'b1,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [IW-1:0] out_idx,
  input logic          out_oldest,
  input logic [N-1:0]  vld,
  input logic [N-1:0]  rdy,
  input logic [N-1:0]  gnt_norm,
  input logic [N-1:0]  gnt_old
);
  AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (vld[out_idx] && rdy[out_idx])); // R3

  AST_FREE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !vld[$past(out_idx)]); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && vld[$past(out_idx)])); // R7

  AST_FULL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> ($countones(vld) <= $past($countones(vld)))); // R2

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_norm) && $onehot0(gnt_old)); // R5

  AST_OLDEST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_oldest == AGE_EN)); // R4
endmodule

bind rs_issue_sel rs_issue_sel_chk #(.N(N), .AGE_EN(AGE_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_idx(out_idx), .out_oldest(out_oldest),
  .vld(vld), .rdy(rdy), .gnt_norm(gnt_norm), .gnt_old(gnt_old)
);

// File: tb/rs_issue_sel_bench.sv
module rs_issue_sel_bench;
  localparam int N  = 8;
  localparam int UW = 16;
  localparam int DW = 32;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          in_valid = 1'b0, in_rdy = 1'b0, out_ready = 1'b0;
  logic [UW-1:0] in_uop = '0;
  logic [DW-1:0] in_data = '0;
  logic [N-1:0]  wake = '0;

  logic          dir [2];
  logic          dv [2];
  logic          dold [2];
  logic [IW-1:0] didx [2];
  logic [UW-1:0] du [2];
  logic [DW-1:0] dd [2];

  rs_issue_sel #(.N(N), .UW(UW), .DW(DW), .AGE_EN(1'b1)) u_rs_issue_sel (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(dir[0]),
    .in_uop(in_uop), .in_data(in_data), .in_rdy(in_rdy), .wake(wake),
    .out_valid(dv[0]), .out_ready(out_ready), .out_uop(du[0]), .out_data(dd[0]),
    .out_idx(didx[0]), .out_oldest(dold[0])
  );

  rs_issue_sel #(.N(N), .UW(UW), .DW(DW), .AGE_EN(1'b0)) u_rs_issue_sel_noage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(dir[1]),
    .in_uop(in_uop), .in_data(in_data), .in_rdy(in_rdy), .wake(wake),
    .out_valid(dv[1]), .out_ready(out_ready), .out_uop(du[1]), .out_data(dd[1]),
    .out_idx(didx[1]), .out_oldest(dold[1])
  );

  int total = 0;
  int bad = 0;

  // behavioural model: config 0 has age logic, config 1 has not
  bit          m_vld [2][N];
  bit          m_rdy [2][N];
  int          m_seq [2][N];
  logic [UW-1:0] m_uop [2][N];
  logic [DW-1:0] m_dat [2][N];
  int          seqc [2];
  bit          prev_stall [2];
  bit          prev_fire [2];
  logic [UW-1:0] next_uop = 16'h0100;

  task automatic check(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic expect_out(int c, output bit v, output int idx, output bit old);
    int nidx = -1;
    int oidx = -1;
    for (int i = 0; i < N; i++) begin
      if (m_vld[c][i] && m_rdy[c][i]) begin
        if (nidx < 0) nidx = i;
        if (oidx < 0 || m_seq[c][i] < m_seq[c][oidx]) oidx = i;
      end
    end
    v   = (nidx >= 0);
    idx = 0;
    old = 1'b0;
    if (v) begin
      idx = (c == 0) ? oidx : nidx;
      old = (c == 0);
    end
  endtask

  task automatic model_update(int c, bit iv, bit irdy, logic [N-1:0] wk, bit ordy);
    bit v, old;
    int idx;
    int k = -1;
    expect_out(c, v, idx, old);
    prev_stall[c] = v && !ordy;
    prev_fire[c]  = v && ordy;
    for (int i = 0; i < N; i++) if (!m_vld[c][i] && k < 0) k = i;
    for (int i = 0; i < N; i++) if (m_vld[c][i] && wk[i]) m_rdy[c][i] = 1'b1;
    if (v && ordy) begin
      m_vld[c][idx] = 1'b0;
      m_rdy[c][idx] = 1'b0;
    end
    if (iv && k >= 0) begin
      m_vld[c][k] = 1'b1;
      m_rdy[c][k] = irdy;
      m_uop[c][k] = in_uop;
      m_dat[c][k] = in_data;
      m_seq[c][k] = seqc[c];
      seqc[c]++;
    end
  endtask

  task automatic compare_all(string vtag);
    for (int c = 0; c < 2; c++) begin
      bit v, old, anyfree;
      int idx;
      string t;
      expect_out(c, v, idx, old);
      anyfree = 1'b0;
      for (int i = 0; i < N; i++) if (!m_vld[c][i]) anyfree = 1'b1;
      check(dir[c] == anyfree, "R2", dir[c], anyfree);
      t = prev_stall[c] ? "R7" : (prev_fire[c] ? "R8" : vtag);
      check(dv[c] == v, t, dv[c], v);
      if (v && dv[c]) begin
        check(didx[c] == IW'(idx), (c == 0) ? "R4" : "R5", didx[c], idx);
        check(dold[c] == old, (c == 0) ? "R4" : "R5", dold[c], old);
        check(du[c] == m_uop[c][idx], "R6", du[c], m_uop[c][idx]);
        check(dd[c] == m_dat[c][idx], "R6", dd[c], m_dat[c][idx]);
      end
    end
  endtask

  task automatic step(bit iv, bit irdy, logic [N-1:0] wk, bit ordy, string vtag);
    in_valid  = iv;
    in_rdy    = irdy;
    wake      = wk;
    out_ready = ordy;
    in_uop    = next_uop;
    in_data   = {next_uop, ~next_uop};
    for (int c = 0; c < 2; c++) model_update(c, iv, irdy, wk, ordy);
    next_uop++;
    @(negedge clk);
    compare_all(vtag);
  endtask

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      seqc[c] = 0;
      prev_stall[c] = 1'b0;
      prev_fire[c] = 1'b0;
      for (int i = 0; i < N; i++) begin
        m_vld[c][i] = 1'b0;
        m_rdy[c][i] = 1'b0;
        m_seq[c][i] = 0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: empty after reset
    for (int c = 0; c < 2; c++) begin
      check(dv[c] == 1'b0, "R1", dv[c], 0);
      check(dir[c] == 1'b1, "R1", dir[c], 1);
    end

    // R3: wake with no occupied entry does nothing
    step(1'b0, 1'b0, '1, 1'b1, "R3");
    step(1'b0, 1'b0, '0, 1'b1, "R3");

    // fill every entry, none ready
    for (int i = 0; i < N; i++) step(1'b1, 1'b0, '0, 1'b1, "R3");
    // R2: offer while full is dropped
    step(1'b1, 1'b1, '0, 1'b1, "R2");

    // wake two entries, hold the consumer off (R7)
    step(1'b0, 1'b0, 8'h48, 1'b0, "R3");
    step(1'b0, 1'b0, '0, 1'b0, "R7");
    step(1'b0, 1'b0, '0, 1'b1, "R8");
    step(1'b0, 1'b0, '0, 1'b1, "R8");

    // refill a low slot as the youngest, then make an older high slot ready
    step(1'b1, 1'b1, '0, 1'b0, "R2");
    step(1'b0, 1'b0, 8'h80, 1'b0, "R4");
    step(1'b0, 1'b0, '0, 1'b1, "R4");
    step(1'b0, 1'b0, '0, 1'b1, "R4");

    // drain everything
    step(1'b0, 1'b0, '1, 1'b1, "R3");
    for (int i = 0; i < N + 2; i++) step(1'b0, 1'b0, '0, 1'b1, "R8");

    // mixed traffic
    for (int n = 0; n < 5000; n++) begin
      step(($urandom % 4) != 0, ($urandom % 3) == 0,
           N'($urandom) & N'($urandom) & N'($urandom),
           ($urandom % 4) != 0, "R3");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule